// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block drives an asynchronous parallel NOR flash bank for a host that only wants to say "program this word", "erase this sector", "read the identity" or "go back to array reading". The block accepts one request at a time and issues the unlock-prefixed write cycles at fixed word offsets above a configurable bank base. After a program or an erase it polls bit 7 of the data lines until the device reports completion or a cycle-count limit runs out. It then answers the host with a two-bit result code.

Before a program begins, the block reads the target word. If the target cannot reach the requested value by clearing bits only, the block refuses the request without writing anything. A write-protect flag on the bus is released for the length of each operation and raised again when the operation ends, on every exit path. Each bus access holds chip-enable, together with either the write or the read strobe, for a parameterised number of clock cycles.

Top module: `norflash_cmd_ctrl`

## Requirements
- R1: Program, erase and identify sequences each open with two unlock writes: data 0xAA to word address BASE+0x554, then data 0x55 to BASE+0x2AB. Command bytes sit in the low byte of the data word and the upper bits are zero.
- R2: A program request (op code 1) that passes the pre-check issues exactly four writes: the two unlock writes, 0xA0 to BASE+0x554, then the request data to the request address.
- R3: An erase request (op code 2) issues exactly six writes: 0xAA, 0x55, 0x80 to BASE+0x554, 0xAA, 0x55, then 0x30 to the request address.
- R4: After a program, the block reads the target again and again until read bit 7 equals bit 7 of the written data. It then ends with result 0. Every poll read goes to the target address.
- R5: After the last erase write, at least SETTLE clock cycles pass before the first poll read. The erase then ends with result 0 at the first read whose bit 7 is 1.
- R6: A program first reads the target word. If (current AND data) differs from data, the request ends with result 2 after that single read, and no write cycle is issued.
- R7: When polling has run for at least PROG_TMO cycles (program) or ERASE_TMO cycles (erase) without completion, the block writes 0xF0 to the request address and ends with result 1.
- R8: An identify request (op code 3) writes 0xAA, 0x55 and 0x90 to BASE+0x554. It then reads BASE+1 and presents the low byte on id_mfg. Next it reads BASE+0 and presents the whole word on id_dev. Finally it writes 0xF0 to BASE and ends with result 0.
- R9: A return-to-read request (op code 0) issues a single write of 0xF0 to BASE and ends with result 0, with no read.
- R10: fl_wprot is 0 from the cycle after a request is accepted until the operation ends, and it is 1 whenever the block is idle. fl_we_n is never low while fl_wprot is 1.
- R11: A request on req_valid is taken in any cycle where busy is 0. busy then stays 1 until the cycle in which ack pulses for one cycle. In that cycle result holds 0 (ok), 1 (timeout) or 2 (not erased), never 3.
- R12: Each bus access holds fl_ce_n low, with exactly one of fl_we_n or fl_oe_n low, for WAIT cycles. At least one cycle with all strobes high separates consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_op | input | 2 | 0 read mode, 1 program, 2 erase, 3 identify |
| req_addr | input | AW | Target word / sector start address |
| req_data | input | DW | Program data |
| busy | output | 1 | Operation in progress |
| ack | output | 1 | One-cycle completion pulse |
| result | output | 2 | Completion code, valid with ack |
| id_mfg | output | 8 | Manufacturer byte from last identify |
| id_dev | output | DW | Device word from last identify |
| fl_addr | output | AW | Flash word address |
| fl_dout | output | DW | Data driven to flash |
| fl_dout_en | output | 1 | Data output enable (write cycle) |
| fl_din | input | DW | Data read from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_wprot | output | 1 | Write-protect flag, released during an operation |

## Verification
Programs are swept over a grid of stored-word and data-word pairs. Pairs that only clear bits must produce the four-write sequence. Pairs that would need a 0 bit set back to 1 must produce a refusal with a single read and no write. Each pair is given a different device busy length, so the count of poll reads tells whether the block compares against bit 7 of the data. Erase runs with short and long busy times show the settle gap and the bit-7-high completion. Devices that never finish, under program and under erase, separate the two timeout limits by elapsed cycles, and they check the closing 0xF0 write. Identify and return-to-read runs check the offsets from a nonzero base and which byte of each ID read is kept.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [1:0] {
        OP_READ_MODE = 2'd0,
        OP_PROGRAM   = 2'd1,
        OP_ERASE     = 2'd2,
        OP_IDENT     = 2'd3
    } nfc_op_e;

    localparam logic [1:0] RES_OK         = 2'd0;
    localparam logic [1:0] RES_TIMEOUT    = 2'd1;
    localparam logic [1:0] RES_NOT_ERASED = 2'd2;

    localparam int unsigned KEY_OFS_A = 32'h0554;
    localparam int unsigned KEY_OFS_B = 32'h02AB;

    localparam logic [7:0] CMD_KEY_1     = 8'hAA;
    localparam logic [7:0] CMD_KEY_2     = 8'h55;
    localparam logic [7:0] CMD_WORD_PROG = 8'hA0;
    localparam logic [7:0] CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0] CMD_ERASE_GO  = 8'h30;
    localparam logic [7:0] CMD_ID_ENTER  = 8'h90;
    localparam logic [7:0] CMD_ARRAY     = 8'hF0;

    typedef enum logic [3:0] {
        S_IDLE, S_PRECHK, S_CMD, S_SETTLE, S_POLL,
        S_ABORT, S_ID_MFG, S_ID_DEV, S_ID_EXIT, S_END
    } nfc_state_e;

    function automatic logic [2:0] last_step(nfc_op_e op);
        case (op)
            OP_READ_MODE: return 3'd0;
            OP_PROGRAM:   return 3'd3;
            OP_ERASE:     return 3'd5;
            default:      return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle #(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int WAIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    output logic          fl_dout_en,
    input  logic [DW-1:0] fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int CW = (WAIT > 1) ? $clog2(WAIT) : 1;

    typedef struct packed {
        logic          active;
        logic          wr;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } phy_t;

    phy_t phy_d, phy_q;

    always_comb begin
        phy_d      = phy_q;
        phy_d.done = 1'b0;
        if (!phy_q.active) begin
            if (start_i) begin
                phy_d.active = 1'b1;
                phy_d.wr     = wr_i;
                phy_d.addr   = addr_i;
                phy_d.wdata  = wdata_i;
                phy_d.cnt    = CW'(WAIT - 1);
            end
        end else if (phy_q.cnt == '0) begin
            phy_d.active = 1'b0;
            phy_d.done   = 1'b1;
            if (!phy_q.wr) begin
                phy_d.rdata = fl_din;
            end
        end else begin
            phy_d.cnt = phy_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q <= '0;
        end else begin
            phy_q <= phy_d;
        end
    end

    assign done_o     = phy_q.done;
    assign rdata_o    = phy_q.rdata;
    assign fl_addr    = phy_q.addr;
    assign fl_dout    = phy_q.wdata;
    assign fl_dout_en = phy_q.active & phy_q.wr;
    assign fl_ce_n    = ~phy_q.active;
    assign fl_we_n    = ~(phy_q.active & phy_q.wr);
    assign fl_oe_n    = ~(phy_q.active & ~phy_q.wr);

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !phy_q.active); // R12

    AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        phy_q.done |-> !phy_q.active && $past(phy_q.active)); // R12

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 16,
    parameter int unsigned BASE      = 0,
    parameter int          PROG_TMO  = 2000,
    parameter int          ERASE_TMO = 200000,
    parameter int          SETTLE    = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          ack,
    output logic [1:0]    result,
    output logic [7:0]    id_mfg,
    output logic [DW-1:0] id_dev,
    output logic          wprot,
    output logic          acc_start,
    output logic          acc_wr,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    input  logic          acc_done,
    input  logic [DW-1:0] acc_rdata
);
    localparam int MAX_PE = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
    localparam int MAXV   = (MAX_PE > SETTLE) ? MAX_PE : SETTLE;
    localparam int TW     = $clog2(MAXV + 2);

    localparam logic [AW-1:0] A_BASE = AW'(BASE);
    localparam logic [AW-1:0] A_ID1  = AW'(BASE + 1);
    localparam logic [AW-1:0] A_KEYA = AW'(BASE + KEY_OFS_A);
    localparam logic [AW-1:0] A_KEYB = AW'(BASE + KEY_OFS_B);

    typedef struct packed {
        nfc_state_e    st;
        logic          pend;
        nfc_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [2:0]    step;
        logic [TW-1:0] cnt;
        logic [1:0]    result;
        logic          ack;
        logic [7:0]    mfg;
        logic [DW-1:0] dev;
        logic          wprot;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [AW-1:0] cmd_a;
    logic [DW-1:0] cmd_d;
    logic          poll_pass;
    logic [TW-1:0] poll_limit;

    function automatic logic [DW-1:0] cw(input logic [7:0] b);
        return DW'(b);
    endfunction

    // Write list of each operation, indexed by step
    always_comb begin
        cmd_a = A_KEYA;
        cmd_d = cw(CMD_KEY_1);
        case (seq_q.op)
            OP_READ_MODE: begin
                cmd_a = A_BASE;
                cmd_d = cw(CMD_ARRAY);
            end
            OP_PROGRAM: begin
                case (seq_q.step)
                    3'd0:    begin cmd_a = A_KEYA;     cmd_d = cw(CMD_KEY_1);     end
                    3'd1:    begin cmd_a = A_KEYB;     cmd_d = cw(CMD_KEY_2);     end
                    3'd2:    begin cmd_a = A_KEYA;     cmd_d = cw(CMD_WORD_PROG); end
                    default: begin cmd_a = seq_q.addr; cmd_d = seq_q.data;        end
                endcase
            end
            OP_ERASE: begin
                case (seq_q.step)
                    3'd0, 3'd3: begin cmd_a = A_KEYA;     cmd_d = cw(CMD_KEY_1);     end
                    3'd1, 3'd4: begin cmd_a = A_KEYB;     cmd_d = cw(CMD_KEY_2);     end
                    3'd2:       begin cmd_a = A_KEYA;     cmd_d = cw(CMD_ERASE_ARM); end
                    default:    begin cmd_a = seq_q.addr; cmd_d = cw(CMD_ERASE_GO);  end
                endcase
            end
            default: begin
                case (seq_q.step)
                    3'd0:    begin cmd_a = A_KEYA; cmd_d = cw(CMD_KEY_1);    end
                    3'd1:    begin cmd_a = A_KEYB; cmd_d = cw(CMD_KEY_2);    end
                    default: begin cmd_a = A_KEYA; cmd_d = cw(CMD_ID_ENTER); end
                endcase
            end
        endcase
    end

    always_comb begin
        poll_pass  = (seq_q.op == OP_PROGRAM) ? (acc_rdata[7] == seq_q.data[7])
                                               : acc_rdata[7];
        poll_limit = (seq_q.op == OP_PROGRAM) ? TW'(PROG_TMO) : TW'(ERASE_TMO);
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.ack = 1'b0;
        acc_start = 1'b0;
        acc_wr    = 1'b0;
        acc_addr  = seq_q.addr;
        acc_wdata = '0;
        case (seq_q.st)
            S_IDLE: begin
                seq_d.wprot = 1'b1;
                if (req_valid) begin
                    seq_d.op    = nfc_op_e'(req_op);
                    seq_d.addr  = req_addr;
                    seq_d.data  = req_data;
                    seq_d.step  = '0;
                    seq_d.pend  = 1'b0;
                    seq_d.wprot = 1'b0;
                    seq_d.st    = (nfc_op_e'(req_op) == OP_PROGRAM) ? S_PRECHK : S_CMD;
                end
            end
            S_PRECHK: begin
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend = 1'b0;
                    if ((acc_rdata & seq_q.data) != seq_q.data) begin
                        seq_d.result = RES_NOT_ERASED;
                        seq_d.st     = S_END;
                    end else begin
                        seq_d.st = S_CMD;
                    end
                end
            end
            S_CMD: begin
                acc_wr    = 1'b1;
                acc_addr  = cmd_a;
                acc_wdata = cmd_d;
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend = 1'b0;
                    seq_d.cnt  = '0;
                    if (seq_q.step == last_step(seq_q.op)) begin
                        case (seq_q.op)
                            OP_READ_MODE: begin
                                seq_d.result = RES_OK;
                                seq_d.st     = S_END;
                            end
                            OP_PROGRAM: seq_d.st = S_POLL;
                            OP_ERASE:   seq_d.st = S_SETTLE;
                            default:    seq_d.st = S_ID_MFG;
                        endcase
                    end else begin
                        seq_d.step = seq_q.step + 1'b1;
                    end
                end
            end
            S_SETTLE: begin
                if (seq_q.cnt >= TW'(SETTLE - 1)) begin
                    seq_d.cnt = '0;
                    seq_d.st  = S_POLL;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            S_POLL: begin
                if (seq_q.cnt != '1) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend = 1'b0;
                    if (poll_pass) begin
                        seq_d.result = RES_OK;
                        seq_d.st     = S_END;
                    end else if (seq_q.cnt >= poll_limit) begin
                        seq_d.st = S_ABORT;
                    end
                end
            end
            S_ABORT: begin
                acc_wr    = 1'b1;
                acc_wdata = cw(CMD_ARRAY);
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend   = 1'b0;
                    seq_d.result = RES_TIMEOUT;
                    seq_d.st     = S_END;
                end
            end
            S_ID_MFG: begin
                acc_addr = A_ID1;
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend = 1'b0;
                    seq_d.mfg  = acc_rdata[7:0];
                    seq_d.st   = S_ID_DEV;
                end
            end
            S_ID_DEV: begin
                acc_addr = A_BASE;
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend = 1'b0;
                    seq_d.dev  = acc_rdata;
                    seq_d.st   = S_ID_EXIT;
                end
            end
            S_ID_EXIT: begin
                acc_wr    = 1'b1;
                acc_addr  = A_BASE;
                acc_wdata = cw(CMD_ARRAY);
                if (!seq_q.pend) begin
                    acc_start  = 1'b1;
                    seq_d.pend = 1'b1;
                end else if (acc_done) begin
                    seq_d.pend   = 1'b0;
                    seq_d.result = RES_OK;
                    seq_d.st     = S_END;
                end
            end
            S_END: begin
                seq_d.wprot = 1'b1;
                seq_d.ack   = 1'b1;
                seq_d.st    = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= S_IDLE;
            seq_q.wprot <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy   = (seq_q.st != S_IDLE);
    assign ack    = seq_q.ack;
    assign result = seq_q.result;
    assign id_mfg = seq_q.mfg;
    assign id_dev = seq_q.dev;
    assign wprot  = seq_q.wprot;

    AST_IDLE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_IDLE) |-> seq_q.wprot); // R10

    AST_ACK_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (result != 2'd3) && !busy); // R11

    AST_BUSY_ENDS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ack); // R11

    AST_PRECHK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_PRECHK) |-> !(acc_start && acc_wr)); // R6

    AST_POLL_READS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && seq_q.st == S_POLL) |-> !acc_wr && acc_addr == seq_q.addr); // R4

endmodule

// File: rtl/norflash_cmd_ctrl.sv
module norflash_cmd_ctrl #(
    parameter int          AW        = 16,
    parameter int          DW        = 16,
    parameter int unsigned BASE      = 0,
    parameter int          WAIT      = 2,
    parameter int          PROG_TMO  = 2000,
    parameter int          ERASE_TMO = 200000,
    parameter int          SETTLE    = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          ack,
    output logic [1:0]    result,
    output logic [7:0]    id_mfg,
    output logic [DW-1:0] id_dev,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    output logic          fl_dout_en,
    input  logic [DW-1:0] fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          fl_wprot
);
    logic          acc_start;
    logic          acc_wr;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic          acc_done;
    logic [DW-1:0] acc_rdata;

    nfc_seq #(
        .AW(AW), .DW(DW), .BASE(BASE),
        .PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO), .SETTLE(SETTLE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .ack(ack), .result(result), .id_mfg(id_mfg), .id_dev(id_dev),
        .wprot(fl_wprot),
        .acc_start(acc_start), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata)
    );

    nfc_bus_cycle #(.AW(AW), .DW(DW), .WAIT(WAIT)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .start_i(acc_start), .wr_i(acc_wr), .addr_i(acc_addr), .wdata_i(acc_wdata),
        .done_o(acc_done), .rdata_o(acc_rdata),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    AST_WRITE_ONLY_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_wprot); // R10

    AST_ACK_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> fl_ce_n && fl_we_n && fl_oe_n); // R11

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ack) |-> fl_ce_n); // R12

endmodule

// File: tb/tb_norflash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_norflash_cmd_ctrl;
    localparam int          AW        = 12;
    localparam int          DW        = 16;
    localparam int unsigned BASE      = 32'h100;
    localparam int          WAIT      = 2;
    localparam int          PROG_TMO  = 40;
    localparam int          ERASE_TMO = 64;
    localparam int          SETTLE    = 8;
    localparam logic [AW-1:0] KA = AW'(BASE + 32'h554);
    localparam logic [AW-1:0] KB = AW'(BASE + 32'h2AB);
    localparam logic [15:0] ID_M = 16'h5AC3;
    localparam logic [15:0] ID_D = 16'h22B9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, ack, fl_dout_en, fl_ce_n, fl_we_n, fl_oe_n, fl_wprot;
    logic [1:0] result;
    logic [7:0] id_mfg;
    logic [DW-1:0] id_dev, fl_dout, fl_din;
    logic [AW-1:0] fl_addr;

    always #2 clk = ~clk;

    norflash_cmd_ctrl #(
        .AW(AW), .DW(DW), .BASE(BASE), .WAIT(WAIT),
        .PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO), .SETTLE(SETTLE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .ack(ack),
        .result(result), .id_mfg(id_mfg), .id_dev(id_dev), .fl_addr(fl_addr),
        .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_wprot(fl_wprot)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [15:0] mem [0:4095];
    int md = 0;           // 0 array, 1 program busy, 2 erase busy, 3 identify
    int rem = 0;
    logic [AW-1:0] busy_a = '0;
    logic [15:0] busy_d = '0;
    int arm_kind = 0;
    int arm_at = 0;
    int arm_lat = 0;
    int nwr = 0;
    int nrd = 0;
    int wp_viol = 0;
    logic [AW-1:0] lw_a [0:15];
    logic [15:0] lw_d [0:15];
    int cyc = 0;
    int last_we_cyc = 0;
    int last_gap = 0;
    bit rd_after_wr = 1'b0;
    int wl = 0;
    int ol = 0;

    always_comb begin
        fl_din = mem[fl_addr];
        if (md == 1 && fl_addr == busy_a && rem > 0)
            fl_din = {mem[fl_addr][15:8], ~busy_d[7], mem[fl_addr][6:0]};
        if (md == 2 && fl_addr == busy_a)
            fl_din = (rem > 0) ? 16'h0000 : 16'hFFFF;
        if (md == 3) begin
            if (fl_addr == AW'(BASE + 1)) fl_din = ID_M;
            else if (fl_addr == AW'(BASE)) fl_din = ID_D;
        end
    end

    always @(posedge fl_we_n) begin
        if (nwr < 16) begin
            lw_a[nwr] = fl_addr;
            lw_d[nwr] = fl_dout;
        end
        nwr++;
        if (fl_wprot === 1'b1) wp_viol++;
        last_we_cyc = cyc;
        rd_after_wr = 1'b1;
        if (nwr == arm_at && arm_kind != 0) begin
            busy_a = fl_addr;
            busy_d = fl_dout;
            rem    = arm_lat;
            md     = arm_kind;
            if (arm_kind == 1) mem[fl_addr] = mem[fl_addr] & fl_dout;
        end else if (fl_dout == 16'h00F0) begin
            md = 0;
        end
    end

    always @(posedge fl_oe_n) begin
        nrd++;
        if ((md == 1 || md == 2) && fl_addr == busy_a) begin
            if (rem > 0) rem--;
            else begin
                if (md == 2) for (int k = 0; k < 16; k++) mem[busy_a + AW'(k)] = 16'hFFFF;
                md = 0;
            end
        end
    end

    always @(negedge fl_oe_n) begin
        if (rd_after_wr) begin
            last_gap = cyc - last_we_cyc;
            rd_after_wr = 1'b0;
        end
    end

    // strobe width monitor, R12
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (fl_we_n === 1'b0) wl++;
            else if (wl != 0) begin check("R12 write strobe width", wl, WAIT); wl = 0; end
            if (fl_oe_n === 1'b0) ol++;
            else if (ol != 0) begin check("R12 read strobe width", ol, WAIT); ol = 0; end
            if (fl_we_n === 1'b0 && fl_oe_n === 1'b0) check("R12 strobes exclusive", 1, 0);
        end
    end

    // ---------------- host side ----------------
    logic [1:0] got_res;
    int elapsed;

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                          input int kind, input int at, input int lat);
        int t;
        @(negedge clk);
        while (busy) @(negedge clk);
        nwr = 0; nrd = 0; wp_viol = 0;
        arm_kind = kind; arm_at = at; arm_lat = lat;
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 1;
        while (!ack && t < 5000) begin @(negedge clk); t++; end
        elapsed = t;
        got_res = result;
        check("R11 ack seen", {31'd0, ack}, 1);
        check("R11 busy low at ack", {31'd0, busy}, 0);
        check("R10 protect raised when idle", {31'd0, fl_wprot}, 1);
        check("R10 no write while protected", wp_viol, 0);
        arm_kind = 0;
    endtask

    task automatic chk_wr(input string tag, input int i, input logic [AW-1:0] ea, input logic [15:0] ed);
        check({tag, " write addr"}, {20'd0, lw_a[i]}, {20'd0, ea});
        check({tag, " write data"}, {16'd0, lw_d[i]}, {16'd0, ed});
    endtask

    initial begin
        logic [15:0] curs [0:4];
        logic [15:0] dats [0:4];
        curs = '{16'hFFFF, 16'h0000, 16'hF0F0, 16'h00FF, 16'h80FF};
        dats = '{16'h0000, 16'h1234, 16'hFF7F, 16'h0080, 16'h80F0};
        for (int k = 0; k < 4096; k++) mem[k] = 16'hFFFF;

        repeat (3) @(negedge clk);
        check("R11 reset busy", {31'd0, busy}, 0);
        check("R11 reset ack", {31'd0, ack}, 0);
        check("R12 reset strobes", {29'd0, fl_ce_n, fl_we_n, fl_oe_n}, 32'h7);
        check("R10 reset protect", {31'd0, fl_wprot}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 return to read
        run_op(2'd0, 12'h050, 16'h0, 0, 0, 0);
        check("R9 result", got_res, 0);
        check("R9 write count", nwr, 1);
        check("R9 read count", nrd, 0);
        chk_wr("R9", 0, AW'(BASE), 16'h00F0);

        // R2 R4 R6 sweep
        for (int ci = 0; ci < 5; ci++) begin
            for (int di = 0; di < 5; di++) begin
                logic [AW-1:0] t;
                bit ok;
                int lat;
                t   = AW'(12'h020 + ci * 5 + di);
                lat = (ci + di) % 4;
                mem[t] = curs[ci];
                ok = ((curs[ci] & dats[di]) == dats[di]);
                run_op(2'd1, t, dats[di], 1, 4, lat);
                if (ok) begin
                    check("R4 program result", got_res, 0);
                    check("R2 program write count", nwr, 4);
                    check("R4 poll read count", nrd, lat + 2);
                    chk_wr("R1", 0, KA, 16'h00AA);
                    chk_wr("R1", 1, KB, 16'h0055);
                    chk_wr("R2", 2, KA, 16'h00A0);
                    chk_wr("R2", 3, t, dats[di]);
                end else begin
                    check("R6 not erased result", got_res, 2);
                    check("R6 no writes", nwr, 0);
                    check("R6 single read", nrd, 1);
                end
            end
        end

        // R3 R5 erase with different busy lengths
        for (int e = 0; e < 2; e++) begin
            logic [AW-1:0] s;
            int lat;
            s   = AW'(12'h800 + e * 16);
            lat = e * 5;
            for (int k = 0; k < 16; k++) mem[s + AW'(k)] = 16'h1234;
            run_op(2'd2, s, 16'h0, 2, 6, lat);
            check("R5 erase result", got_res, 0);
            check("R3 erase write count", nwr, 6);
            check("R5 erase poll reads", nrd, lat + 1);
            check("R5 settle gap", {31'd0, (last_gap >= SETTLE)}, 1);
            chk_wr("R1", 0, KA, 16'h00AA);
            chk_wr("R1", 1, KB, 16'h0055);
            chk_wr("R3", 2, KA, 16'h0080);
            chk_wr("R3", 3, KA, 16'h00AA);
            chk_wr("R3", 4, KB, 16'h0055);
            chk_wr("R3", 5, s, 16'h0030);
            check("R5 sector erased", {16'd0, mem[s + 12'd3]}, 32'hFFFF);
        end

        // R7 program timeout
        mem[12'h0A0] = 16'hFFFF;
        run_op(2'd1, 12'h0A0, 16'h0011, 1, 4, 1000000);
        check("R7 program timeout result", got_res, 1);
        check("R7 program timeout writes", nwr, 5);
        chk_wr("R7", 4, 12'h0A0, 16'h00F0);
        check("R7 program limit lower", {31'd0, (elapsed >= PROG_TMO)}, 1);
        check("R7 program limit upper", {31'd0, (elapsed <= PROG_TMO + 40)}, 1);

        // R7 erase timeout
        run_op(2'd2, 12'h900, 16'h0, 2, 6, 1000000);
        check("R7 erase timeout result", got_res, 1);
        check("R7 erase timeout writes", nwr, 7);
        chk_wr("R7", 6, 12'h900, 16'h00F0);
        check("R7 erase limit lower", {31'd0, (elapsed >= ERASE_TMO + SETTLE)}, 1);
        check("R7 erase limit upper", {31'd0, (elapsed <= ERASE_TMO + SETTLE + 45)}, 1);

        // R8 identify
        run_op(2'd3, 12'h0, 16'h0, 3, 3, 0);
        check("R8 ident result", got_res, 0);
        check("R8 ident writes", nwr, 4);
        check("R8 ident reads", nrd, 2);
        chk_wr("R1", 0, KA, 16'h00AA);
        chk_wr("R1", 1, KB, 16'h0055);
        chk_wr("R8", 2, KA, 16'h0090);
        chk_wr("R8", 3, AW'(BASE), 16'h00F0);
        check("R8 manufacturer byte", {24'd0, id_mfg}, {24'd0, ID_M[7:0]});
        check("R8 device word", {16'd0, id_dev}, {16'd0, ID_D});

        // R11 back-to-back acceptance after completion
        run_op(2'd0, 12'h0, 16'h0, 0, 0, 0);
        check("R11 second request served", got_res, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule